// File: doc/BRIEF.md
# Drum Access Timer

This block times word accesses to a rotating drum store. The store is organised as tracks of 32 words, and the drum turns one word position per clock. A requester presents a 10-bit logical address with a read, a position-free read, a full write or a masked write. The block turns that address into an absolute address using a 4-bit working-store register. It then spends any track-switch penalty and waits until the wanted word is under the heads. In that cycle it transfers the word to or from an internal synchronous RAM. It then pulses done and reports how many cycles the access took.

The block holds a memory-location register that records the last logical address loaded. Moving to a different track costs a fixed penalty, and staying on the same track costs none. An access may reuse the held register instead of a new address. An access may also request a vector step, which advances the word field of the register after the transfer while the track stays the same. Running 32 stepped accesses in a row therefore covers a whole track.

Top module: `drum_access_timer`

## Requirements
- R1: During reset and right after it, `word_pos_o` is 0, `ws_o` is 1, `ml_o` is 0, and `busy_o` and `done_o` are low.
- R2: `word_pos_o` increases by one, modulo 32, on every clock edge out of reset.
- R3: The absolute address `acc_addr_o` (13 bits) is formed from the logical address. When logical bit 9 is 1, it is `{ws, laddr[8:0]}`. When bit 9 is 0, it is the logical address zero-extended.
- R4: Let w0 be `word_pos_o` in the cycle a request is accepted, and P the penalty. A read or write transfers in the cycle where the word position equals the target word, after waiting W = (target − (w0+1+P)) mod 32 cycles. `done_o` is high in the cycle after the transfer, and `cycles_o` = P+W+1.
- R5: The penalty P is 6 cycles when `laddr_i[9:5]` differs from `ml_o[9:5]` and `use_ml_i` is 0. Otherwise P is 0.
- R6: A special read (`op_i`=1) ignores the word field of the address and transfers at word (w0+1+P) mod 32 with W=0. `acc_addr_o[4:0]` shows that word.
- R7: A masked write (`op_i`=3) updates only the bits where `wmask_i` is 1. A full write (`op_i`=2) replaces the whole word and ignores `wmask_i`.
- R8: A normal read (`op_i`=0) or a special read returns on `rdata_o`, during the done cycle, the last value written to that absolute word.
- R9: After the transfer, `ml_o` holds the address used. When `vec_i` was 1, its word field `ml_o[4:0]` advances by one modulo 32 and the track bits do not change. With `use_ml_i`=1, the held `ml_o` is used in place of `laddr_i`.
- R10: A request is accepted only while `busy_o` is low. A request raised while busy changes neither the access in progress, `ml_o`, nor the done count.
- R11: `busy_o` rises in the cycle after acceptance and stays high until the done cycle. `done_o` lasts exactly one cycle, and `busy_o` is low in the following cycle.
- R12: `ws_set_i` loads `ws_val_i` into the working store, and the new value appears on `ws_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one drum word position per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when idle |
| op_i | input | 2 | 0 read, 1 special read, 2 full write, 3 masked write |
| use_ml_i | input | 1 | Use held memory-location register instead of laddr_i |
| vec_i | input | 1 | Advance word field of the register after the transfer |
| laddr_i | input | 10 | Logical address (bit 9 store select, 8:5 track, 4:0 word) |
| wdata_i | input | 32 | Write data |
| wmask_i | input | 32 | Bit mask for masked write |
| ws_set_i | input | 1 | Load working-store register |
| ws_val_i | input | 4 | New working-store value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with done_o |
| cycles_o | output | 6 | Elapsed cycles of the last access |
| acc_addr_o | output | 13 | Absolute address actually transferred |
| ml_o | output | 10 | Memory-location register |
| word_pos_o | output | 5 | Word currently under the heads |
| ws_o | output | 4 | Working-store register |

## Verification
Several rules are checked every cycle: the word position steps by one, every transfer happens while its word is under the heads, done never lasts two cycles, and the latched target cannot move while busy. The penalty phase and the elapsed count also stay within their bounds, and the track field is held across a vector step. The exact latency for each start position, the size of the switch penalty, the masked-write merge, the data returned, and the address mapping under different working stores can only be shown by the bench. It compares each of these against values it computes itself from the word position it observes at request time.

// File: rtl/drum_timer_pkg.sv
package drum_timer_pkg;

   typedef enum logic [1:0] {
      OP_READ    = 2'd0,
      OP_SPECIAL = 2'd1,
      OP_WRITE   = 2'd2,
      OP_WMASK   = 2'd3
   } drum_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PENALTY,
      ST_SEEK,
      ST_DONE
   } drum_state_e;

endpackage

// File: rtl/drum_word_clock.sv
module drum_word_clock #(
   parameter int WORD_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [WORD_BITS-1:0] word_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_o <= '0;
      else        word_o <= word_o + 1'b1;
   end

   // R2
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> word_o == $past(word_o) + 1'b1);

endmodule

// File: rtl/drum_addr_map.sv
module drum_addr_map #(
   parameter int LADDR_W = 10,
   parameter int STORE_W = 4,
   localparam int LOCAL_W = LADDR_W - 1,
   localparam int ABS_W   = LOCAL_W + STORE_W
) (
   input  logic [LADDR_W-1:0] laddr_i,
   input  logic [STORE_W-1:0] ws_i,
   output logic [ABS_W-1:0]   abs_o
);

   generate
      if (STORE_W < 1) begin : g_bad_store
         $error("drum_addr_map: STORE_W must be at least 1");
      end
   endgenerate

   always_comb begin
      if (laddr_i[LADDR_W-1]) abs_o = {ws_i, laddr_i[LOCAL_W-1:0]};
      else                    abs_o = ABS_W'(laddr_i);
   end

endmodule

// File: rtl/drum_ram.sv
module drum_ram #(
   parameter int AW       = 11,
   parameter int DW       = 32,
   parameter bit BIT_MASK = 1'b1
) (
   input  logic          clk,
   input  logic          en_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wd_i,
   input  logic [DW-1:0] wm_i,
   output logic [DW-1:0] rd_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [0:DEPTH-1];
   logic [DW-1:0] merged;

   generate
      if (BIT_MASK) begin : g_bitmask
         always_comb merged = (mem[addr_i] & ~wm_i) | (wd_i & wm_i);
      end else begin : g_fullword
         logic [DW-1:0] unused_mask;
         always_comb begin
            unused_mask = wm_i;
            merged      = wd_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en_i) begin
         if (we_i) mem[addr_i] <= merged;
         rd_o <= mem[addr_i];
      end
   end

endmodule

// File: rtl/drum_access_timer.sv
module drum_access_timer
   import drum_timer_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int LADDR_W         = 10,
   parameter int WORDS_PER_TRACK = 32,
   parameter int STORE_W         = 4,
   parameter int TRACK_SWITCH    = 6,
   parameter int RAM_AW          = 11,
   parameter bit BIT_MASK        = 1'b1,
   parameter int WS_RESET        = 1,
   localparam int WORD_BITS = $clog2(WORDS_PER_TRACK),
   localparam int ABS_W     = LADDR_W - 1 + STORE_W,
   localparam int CNT_W     = $clog2(TRACK_SWITCH + WORDS_PER_TRACK + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [1:0]           op_i,
   input  logic                 use_ml_i,
   input  logic                 vec_i,
   input  logic [LADDR_W-1:0]   laddr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [DATA_W-1:0]    wmask_i,
   input  logic                 ws_set_i,
   input  logic [STORE_W-1:0]   ws_val_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [CNT_W-1:0]     cycles_o,
   output logic [ABS_W-1:0]     acc_addr_o,
   output logic [LADDR_W-1:0]   ml_o,
   output logic [WORD_BITS-1:0] word_pos_o,
   output logic [STORE_W-1:0]   ws_o
);

   localparam int PEN_W = $clog2(TRACK_SWITCH + 1);

   generate
      if (WORDS_PER_TRACK != (1 << WORD_BITS)) begin : g_bad_words
         $error("drum_access_timer: WORDS_PER_TRACK must be a power of two");
      end
      if (TRACK_SWITCH < 1) begin : g_bad_pen
         $error("drum_access_timer: TRACK_SWITCH must be at least 1");
      end
      if (RAM_AW > ABS_W || RAM_AW < WORD_BITS) begin : g_bad_ram
         $error("drum_access_timer: RAM_AW out of range");
      end
      if (LADDR_W <= WORD_BITS + 1) begin : g_bad_laddr
         $error("drum_access_timer: LADDR_W too small for a track field");
      end
   endgenerate

   drum_state_e          state_q;
   logic [PEN_W-1:0]     pen_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [ABS_W-1:0]     tgt_q;
   logic [ABS_W-1:0]     acc_q;
   drum_op_e             op_q;
   logic                 vec_q;
   logic [DATA_W-1:0]    wd_q;
   logic [DATA_W-1:0]    wm_q;
   logic [LADDR_W-1:0]   ml_q;
   logic [STORE_W-1:0]   ws_q;
   logic [WORD_BITS-1:0] word_pos;

   logic                 accept;
   logic [LADDR_W-1:0]   ml_sel;
   logic                 track_sw;
   logic [ABS_W-1:0]     abs_sel;
   logic                 is_spec;
   logic                 xfer;
   logic [ABS_W-1:0]     xfer_addr;
   logic                 ram_we;
   logic [DATA_W-1:0]    ram_mask;

   drum_word_clock #(.WORD_BITS(WORD_BITS)) u_word_clock (
      .clk    (clk),
      .rst_n  (rst_n),
      .word_o (word_pos)
   );

   always_comb begin
      accept   = (state_q == ST_IDLE) && req_i;
      ml_sel   = use_ml_i ? ml_q : laddr_i;
      track_sw = !use_ml_i &&
                 (laddr_i[LADDR_W-1:WORD_BITS] != ml_q[LADDR_W-1:WORD_BITS]);
   end

   drum_addr_map #(.LADDR_W(LADDR_W), .STORE_W(STORE_W)) u_addr_map (
      .laddr_i (ml_sel),
      .ws_i    (ws_q),
      .abs_o   (abs_sel)
   );

   always_comb begin
      is_spec   = (op_q == OP_SPECIAL);
      xfer      = (state_q == ST_SEEK) &&
                  (is_spec || (word_pos == tgt_q[WORD_BITS-1:0]));
      xfer_addr = is_spec ? {tgt_q[ABS_W-1:WORD_BITS], word_pos} : tgt_q;
      ram_we    = xfer && ((op_q == OP_WRITE) || (op_q == OP_WMASK));
      ram_mask  = (op_q == OP_WMASK) ? wm_q : '1;
   end

   drum_ram #(.AW(RAM_AW), .DW(DATA_W), .BIT_MASK(BIT_MASK)) u_ram (
      .clk    (clk),
      .en_i   (xfer),
      .we_i   (ram_we),
      .addr_i (xfer_addr[RAM_AW-1:0]),
      .wd_i   (wd_q),
      .wm_i   (ram_mask),
      .rd_o   (rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pen_q   <= '0;
         cnt_q   <= '0;
         tgt_q   <= '0;
         acc_q   <= '0;
         op_q    <= OP_READ;
         vec_q   <= 1'b0;
         wd_q    <= '0;
         wm_q    <= '0;
         ml_q    <= '0;
         ws_q    <= STORE_W'(WS_RESET);
      end else begin
         if (ws_set_i) ws_q <= ws_val_i;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  ml_q  <= ml_sel;
                  tgt_q <= abs_sel;
                  op_q  <= drum_op_e'(op_i);
                  vec_q <= vec_i;
                  wd_q  <= wdata_i;
                  wm_q  <= wmask_i;
                  cnt_q <= '0;
                  if (track_sw) begin
                     pen_q   <= PEN_W'(TRACK_SWITCH);
                     state_q <= ST_PENALTY;
                  end else begin
                     state_q <= ST_SEEK;
                  end
               end
            end
            ST_PENALTY: begin
               cnt_q <= cnt_q + 1'b1;
               pen_q <= pen_q - 1'b1;
               if (pen_q == PEN_W'(1)) state_q <= ST_SEEK;
            end
            ST_SEEK: begin
               cnt_q <= cnt_q + 1'b1;
               if (xfer) begin
                  acc_q   <= xfer_addr;
                  state_q <= ST_DONE;
                  if (vec_q) ml_q[WORD_BITS-1:0] <= ml_q[WORD_BITS-1:0] + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy_o     = (state_q != ST_IDLE);
      done_o     = (state_q == ST_DONE);
      cycles_o   = cnt_q;
      acc_addr_o = acc_q;
      ml_o       = ml_q;
      word_pos_o = word_pos;
      ws_o       = ws_q;
   end

   // R4
   xfer_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> acc_addr_o[WORD_BITS-1:0] == word_pos_o - WORD_BITS'(1));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(tgt_q));

   // R5
   pen_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PENALTY) |-> cnt_q < CNT_W'(TRACK_SWITCH));

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cycles_o != '0) &&
                 (cycles_o <= CNT_W'(TRACK_SWITCH + WORDS_PER_TRACK)));

   // R9
   vec_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ml_q[LADDR_W-1:WORD_BITS] == $past(ml_q[LADDR_W-1:WORD_BITS]));

endmodule

// File: tb/drum_access_timer_tb_top.sv
module drum_access_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req;
   logic [1:0]  op;
   logic        use_ml;
   logic        vec;
   logic [9:0]  laddr;
   logic [31:0] wdata;
   logic [31:0] wmask;
   logic        ws_set;
   logic [3:0]  ws_val;
   logic        busy_o;
   logic        done_o;
   logic [31:0] rdata_o;
   logic [5:0]  cycles_o;
   logic [12:0] acc_addr_o;
   logic [9:0]  ml_o;
   logic [4:0]  word_pos_o;
   logic [3:0]  ws_o;

   always #5 clk = ~clk;

   drum_access_timer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .op_i       (op),
      .use_ml_i   (use_ml),
      .vec_i      (vec),
      .laddr_i    (laddr),
      .wdata_i    (wdata),
      .wmask_i    (wmask),
      .ws_set_i   (ws_set),
      .ws_val_i   (ws_val),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .rdata_o    (rdata_o),
      .cycles_o   (cycles_o),
      .acc_addr_o (acc_addr_o),
      .ml_o       (ml_o),
      .word_pos_o (word_pos_o),
      .ws_o       (ws_o)
   );

   int          total = 0;
   int          bad = 0;
   logic [31:0] model [0:2047];
   bit          known [0:2047];
   logic [9:0]  bml = '0;
   logic [3:0]  bws = 4'd1;

   function automatic logic [12:0] emap(input logic [9:0] la, input logic [3:0] ws);
      return la[9] ? {ws, la[8:0]} : {3'b000, la};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic set_ws(input logic [3:0] v);
      @(negedge clk);
      ws_set = 1'b1;
      ws_val = v;
      @(negedge clk);
      ws_set = 1'b0;
      bws = v;
      chk(ws_o == v, "R12", "ws_o", ws_o, v);
   endtask

   task automatic access(input logic [1:0] aop, input bit uml, input bit avec,
                         input logic [9:0] la, input logic [31:0] wd,
                         input logic [31:0] wm, input bit spam);
      logic [9:0]  eff;
      logic [12:0] ab;
      logic [12:0] ea;
      logic [4:0]  w0;
      logic [4:0]  xw;
      logic [10:0] idx;
      int          pen;
      int          w;
      int          start;
      int          n;
      @(negedge clk);
      w0    = word_pos_o;
      eff   = uml ? bml : la;
      pen   = (!uml && (la[9:5] != bml[9:5])) ? 6 : 0;
      ab    = emap(eff, bws);
      start = (int'(w0) + 1 + pen) % 32;
      if (aop == 2'd1) begin
         xw = 5'(start);
         w  = 0;
      end else begin
         xw = ab[4:0];
         w  = (int'(ab[4:0]) - start + 32) % 32;
      end
      ea     = {ab[12:5], xw};
      req    = 1'b1;
      op     = aop;
      use_ml = uml;
      vec    = avec;
      laddr  = la;
      wdata  = wd;
      wmask  = wm;
      @(negedge clk);
      req = 1'b0;
      n   = 1;
      chk(busy_o == 1'b1, "R11", "busy after accept", busy_o, 1);
      while (!done_o && n < 100) begin
         if (spam && n == 2) begin
            req   = 1'b1;
            op    = 2'd2;
            laddr = ~la;
            wdata = 32'hDEAD_BEEF;
            wmask = '1;
         end
         @(negedge clk);
         n++;
      end
      req = 1'b0;
      chk(n == pen + w + 2, (pen != 0) ? "R5" : "R4", "done latency", n, pen + w + 2);
      chk(cycles_o == 6'(pen + w + 1), "R4", "cycles_o", cycles_o, pen + w + 1);
      chk(acc_addr_o == ea, (aop == 2'd1) ? "R6" : "R3", "acc_addr_o", acc_addr_o, ea);
      bml = eff;
      if (avec) bml[4:0] = bml[4:0] + 5'd1;
      chk(ml_o == bml, "R9", "ml_o", ml_o, bml);
      idx = ea[10:0];
      if (aop == 2'd2) begin
         model[idx] = wd;
         known[idx] = 1'b1;
      end else if (aop == 2'd3) begin
         model[idx] = (model[idx] & ~wm) | (wd & wm);
         known[idx] = 1'b1;
      end else if (known[idx]) begin
         chk(rdata_o == model[idx], "R8", "rdata_o", rdata_o, model[idx]);
      end
      @(negedge clk);
      chk(!done_o && !busy_o, spam ? "R10" : "R11", "idle after done",
          {done_o, busy_o}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [4:0] prev;
      rst_n  = 1'b0;
      req    = 1'b0;
      op     = '0;
      use_ml = 1'b0;
      vec    = 1'b0;
      laddr  = '0;
      wdata  = '0;
      wmask  = '0;
      ws_set = 1'b0;
      ws_val = '0;
      for (int i = 0; i < 2048; i++) known[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(word_pos_o == 5'd0, "R1", "word_pos_o", word_pos_o, 0);
      chk(ws_o == 4'd1, "R1", "ws_o", ws_o, 1);
      chk(ml_o == 10'd0, "R1", "ml_o", ml_o, 0);
      chk(!busy_o && !done_o, "R1", "busy/done", {busy_o, done_o}, 0);
      rst_n = 1'b1;
      chk(word_pos_o == 5'd0, "R1", "word_pos_o after release", word_pos_o, 0);

      // R2 rotation
      prev = word_pos_o;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(word_pos_o == prev + 5'd1, "R2", "word_pos_o step", word_pos_o, prev + 5'd1);
         prev = word_pos_o;
      end

      set_ws(4'd2);

      // fill track 5 of the working store
      for (int i = 0; i < 32; i++)
         access(2'd2, 1'b0, 1'b0, {1'b1, 4'd5, 5'(i)}, {8'hA5, 8'(i), 16'(i * 97)}, '0, 1'b0);

      // R4 start-position sweep on one track
      for (int i = 0; i < 64; i++) begin
         repeat (i % 5) @(negedge clk);
         access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'((i * 7) % 32)}, '0, '0, 1'b0);
      end

      // R5 track switching between stores
      for (int i = 0; i < 4; i++)
         access(2'd2, 1'b0, 1'b0, {1'b0, 4'd2, 5'(i * 3)}, 32'h0B00_0000 | 32'(i), '0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'(i * 5)}, '0, '0, 1'b0);
         access(2'd0, 1'b0, 1'b0, {1'b0, 4'd2, 5'((i % 4) * 3)}, '0, '0, 1'b0);
      end

      // R6 special reads, first one with a track switch
      for (int i = 0; i < 6; i++) begin
         repeat (i) @(negedge clk);
         access(2'd1, 1'b0, 1'b0, {1'b1, 4'd5, 5'd0}, '0, '0, 1'b0);
      end

      // R7 masked and full writes
      access(2'd3, 1'b0, 1'b0, {1'b1, 4'd5, 5'd3}, 32'h1234_5678, 32'h0F0F_00FF, 1'b0);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd3}, '0, '0, 1'b0);
      access(2'd2, 1'b0, 1'b0, {1'b1, 4'd5, 5'd9}, 32'hCAFE_F00D, 32'h0, 1'b0);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd9}, '0, '0, 1'b0);
      access(2'd3, 1'b0, 1'b0, {1'b1, 4'd5, 5'd9}, 32'h0000_0000, 32'hFFFF_0000, 1'b0);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd9}, '0, '0, 1'b0);

      // R9 vector pass over a whole track, starting near the wrap
      access(2'd2, 1'b0, 1'b1, {1'b1, 4'd7, 5'd29}, 32'h7700_0000, '0, 1'b0);
      for (int k = 1; k < 32; k++)
         access(2'd2, 1'b1, 1'b1, '0, 32'h7700_0000 | 32'(k), '0, 1'b0);
      chk(ml_o == {1'b1, 4'd7, 5'd29}, "R9", "ml_o after 32 steps", ml_o, {1'b1, 4'd7, 5'd29});
      access(2'd0, 1'b0, 1'b1, {1'b1, 4'd7, 5'd29}, '0, '0, 1'b0);
      for (int k = 1; k < 32; k++)
         access(2'd0, 1'b1, 1'b1, '0, '0, '0, 1'b0);

      // R10 requests while busy
      for (int i = 0; i < 4; i++)
         access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'(i * 11)}, '0, '0, 1'b1);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd0}, '0, '0, 1'b0);

      // R3 mapping under another working store
      set_ws(4'd9);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd4}, '0, '0, 1'b0);
      access(2'd0, 1'b0, 1'b0, {1'b0, 4'd2, 5'd3}, '0, '0, 1'b0);
      set_ws(4'd2);
      access(2'd0, 1'b0, 1'b0, {1'b1, 4'd5, 5'd4}, '0, '0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule